// File: doc/BRIEF.md
# Selectable-Rate 8N1 Serial Transmitter

This block takes one 8-bit word through a valid/ready handshake and sends it on a single serial line that rests high. Each frame has one low start bit, then the eight data bits with the least significant bit first, and then one high stop bit. There is no parity bit. The line rate is chosen at run time from three preset bit periods. An internal divider derives these periods from the system clock, so no separate baud clock is needed.

The upstream side offers a word by raising `s_valid`. The word is taken on any clock edge where `s_valid` and `s_ready` are both high. `s_ready` is low for the whole frame, which is how back-pressure works: a producer must hold its word until `s_ready` returns. While the block is busy, `s_valid` has no effect. The word and the rate select are both captured at acceptance, so later changes on those inputs do not disturb a frame that has already started. `busy` is high for the length of the frame. `done` pulses for one cycle at the edge where `busy` falls, and a new word can be accepted in that same cycle.

With the default parameters and a 60 MHz system clock, the bit periods are 40, 50 and 30 clocks. These give 1.5, 1.2 and 2.0 MBaud.

Top module: `uart8n1_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0, `done` is 0 and `s_ready` is 1, and `txd` stays 1 whenever no frame is in progress.
- R2: A frame is ten bit periods long: one start bit at 0, then data bits 0 through 7 with the least significant bit first, then one stop bit at 1.
- R3: A word is accepted on a rising clock edge where `s_valid` and `s_ready` are both 1. `s_ready` equals the inverse of `busy`. The word sent is the value of `s_data` at acceptance, and later changes of `s_data` have no effect on it.
- R4: `busy` goes high at the accepting edge and stays high for exactly 10×P clock cycles, where P is the bit period of the frame. The start bit appears on `txd` at that same edge.
- R5: `done` is high for exactly one cycle. It rises at the edge where `busy` falls, which is the end of the full stop-bit period.
- R6: `rate_sel` selects P: 2'b00 gives 40 clocks (1.5 MBaud at 60 MHz, the reset default), 2'b01 gives 50 clocks (1.2 MBaud), 2'b10 gives 30 clocks (2.0 MBaud), and 2'b11 is treated the same as 2'b00.
- R7: `s_valid` asserted while `busy` is 1 is ignored. The current frame continues unchanged and no extra frame follows.
- R8: `rate_sel` is sampled only at acceptance. A change during a frame first affects the next frame.
- R9: A word offered in the cycle where `done` is high is accepted at once, and its start bit follows the previous stop bit with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Bit-rate select, sampled at acceptance |
| s_valid | input | 1 | Upstream word offered |
| s_ready | output | 1 | Block can accept a word (idle) |
| s_data | input | 8 | Word to send |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Any fault in the divider counter or the latched divisor shows up as bit cells that are too short or too long. The bench samples `txd` on every cycle of the frame, so such a fault appears within the first bit period. A wrong bit index or a wrong shift in the frame state machine puts a wrong level in a data cell. If the stop-bit handling is wrong, `busy` falls and `done` pulses one or more cycles away from the 10×P mark, and the bench sees this at the end of that same frame. A frame taken while busy, or a rate change applied too early, shows as a start bit in the middle of a frame or as cells with the wrong length.

// File: rtl/uart8n1_pkg.sv
package uart8n1_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2,
    PH_STOP  = 2'd3
  } phase_t;

  // R6: rate code to bit period in clocks; code 3 falls back to the default
  function automatic int unsigned period_for(input logic [1:0] sel,
                                             input int unsigned p_std,
                                             input int unsigned p_slow,
                                             input int unsigned p_fast);
    case (sel)
      2'b01:   return p_slow;
      2'b10:   return p_fast;
      default: return p_std;
    endcase
  endfunction

endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic [CW-1:0] period_in,
  output logic          tick
);

  logic [CW-1:0] period_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      cnt_q    <= '0;
    end else if (restart) begin
      period_q <= period_in;
      cnt_q    <= period_in - CW'(1);
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= period_q - CW'(1);
      else             cnt_q <= cnt_q - CW'(1);
    end
  end

  assign tick = run && (cnt_q == '0);

  // R8: divisor held for the whole frame
  assert_rate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart) |=> $stable(period_q));

  // R4: countdown never exceeds the latched period
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < period_q));

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart8n1_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] word,
  input  logic              tick,
  output logic              busy,
  output logic              done,
  output logic              txd
);

  localparam int unsigned IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  phase_t            phase_q;
  logic [DATA_W-1:0] sh_q;
  logic [IW-1:0]     idx_q;
  logic              txd_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
      txd_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: if (accept) begin
          phase_q <= PH_START;
          sh_q    <= word;
          idx_q   <= '0;
          txd_q   <= 1'b0;
        end
        PH_START: if (tick) begin
          phase_q <= PH_DATA;
          txd_q   <= sh_q[0];
          sh_q    <= sh_q >> 1;
        end
        PH_DATA: if (tick) begin
          if (idx_q == IW'(DATA_W - 1)) begin
            phase_q <= PH_STOP;
            txd_q   <= 1'b1;
          end else begin
            idx_q <= idx_q + IW'(1);
            txd_q <= sh_q[0];
            sh_q  <= sh_q >> 1;
          end
        end
        PH_STOP: if (tick) begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy = (phase_q != PH_IDLE);
  assign done = done_q;
  assign txd  = txd_q;

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  assert_cell_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(txd));
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> busy);

endmodule

// File: rtl/uart8n1_tx.sv
module uart8n1_tx
  import uart8n1_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned P_STD  = 40,
  parameter int unsigned P_SLOW = 50,
  parameter int unsigned P_FAST = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rate_sel,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              txd,
  output logic              busy,
  output logic              done
);

  localparam int unsigned P_MAX1 = (P_STD > P_SLOW) ? P_STD : P_SLOW;
  localparam int unsigned P_MAX  = (P_MAX1 > P_FAST) ? P_MAX1 : P_FAST;
  localparam int unsigned CW     = $clog2(P_MAX + 1);

  logic          accept;
  logic          tick;
  logic          busy_w;
  logic [CW-1:0] period_sel;

  assign s_ready    = !busy_w;
  assign accept     = s_valid && !busy_w;
  assign period_sel = CW'(period_for(rate_sel, P_STD, P_SLOW, P_FAST));
  assign busy       = busy_w;

  uart_baud_tick #(.CW(CW)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (accept),
    .run       (busy_w),
    .period_in (period_sel),
    .tick      (tick)
  );

  uart_tx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .word   (s_data),
    .tick   (tick),
    .busy   (busy_w),
    .done   (done),
    .txd    (txd)
  );

  // R3: an accepted word always starts a frame on the next cycle
  assert_accept_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (busy && !txd));

endmodule

// File: tb/sim_uart8n1_tx.sv
module sim_uart8n1_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = 8'h00;
  logic       txd, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  uart8n1_tx u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .txd(txd), .busy(busy), .done(done)
  );

  function automatic int period_of(input logic [1:0] sel);  // R6
    case (sel)
      2'b01:   return 50;
      2'b10:   return 30;
      default: return 40;
    endcase
  endfunction

  function automatic logic cell_of(input logic [7:0] d, input int k);  // R2
    if (k == 0) return 1'b0;
    if (k == 9) return 1'b1;
    return d[k-1];
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // Called right after a negedge; offers word, follows whole frame, returns on
  // the negedge in which done is expected high.
  task automatic send(input logic [7:0] d, input logic [1:0] sel,
                      input bit scramble, input bit poke);
    int p;
    p = period_of(sel);
    s_valid = 1'b1; s_data = d; rate_sel = sel;
    chk("R3 ready before accept", s_ready, 1'b1);
    @(posedge clk);
    for (int j = 1; j <= 10*p + 1; j++) begin
      @(negedge clk);
      if (j == 1) begin
        s_valid = 1'b0;
        if (scramble) begin s_data = ~d; rate_sel = sel ^ 2'b11; end
      end
      if (poke && j == 3*p + p/2) begin s_valid = 1'b1; s_data = 8'hA5; end
      if (poke && j == 3*p + p/2 + 3) s_valid = 1'b0;
      if (j <= 10*p) begin
        chk("R2/R6 cell level", txd, cell_of(d, (j-1)/p));
        chk("R4 busy", busy, 1'b1);
        if (j == 1 || j == 10*p) chk("R3 ready low in frame", s_ready, 1'b0);
        chk("R5 no early done", done, 1'b0);
      end else begin
        chk("R4 busy fall", busy, 1'b0);
        chk("R5 done pulse", done, 1'b1);
        chk("R1 idle high", txd, 1'b1);
      end
    end
  endtask

  task automatic idle_gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R5/R7 idle done low", done, 1'b0);
      chk("R7 stays idle", busy, 1'b0);
      chk("R1 idle line", txd, 1'b1);
    end
  endtask

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1 reset txd", txd, 1'b1);
    chk("R1 reset busy", busy, 1'b0);
    chk("R1 reset done", done, 1'b0);
    chk("R1 reset ready", s_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    send(8'h55, 2'b00, 1'b0, 1'b0); idle_gap(5);   // R6 default rate
    send(8'h00, 2'b01, 1'b0, 1'b0); idle_gap(3);   // R6 slow
    send(8'hFF, 2'b10, 1'b0, 1'b0); idle_gap(3);   // R6 fast
    send(8'h81, 2'b11, 1'b0, 1'b0); idle_gap(3);   // R6 code 11
    send(8'h3C, 2'b10, 1'b1, 1'b1); idle_gap(4);   // R3 R7 R8
    send(8'hC3, 2'b01, 1'b0, 1'b0);                // R9 back-to-back
    send(8'h96, 2'b00, 1'b0, 1'b0);
    send(8'h01, 2'b10, 1'b1, 1'b0); idle_gap(2);

    for (int n = 0; n < 24; n++) begin
      logic [7:0] d;
      logic [1:0] s;
      d = 8'($urandom());
      s = 2'($urandom());
      send(d, s, 1'($urandom()), 1'($urandom()));
      if ($urandom_range(0, 2) != 0) idle_gap($urandom_range(1, 6));
    end
    idle_gap(2);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule